// File: doc/BRIEF.md
# Multimode Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port that software runs through a small byte-wide register file. A programmable divider turns the system clock into a tick at sixteen times the bit rate. Any divisor is allowed, so nonstandard rates are possible. The transmitter sends characters of five to eight data bits with optional even or odd parity. Its stop time is set in sixteenths of a bit, from one bit up to two bits. The receiver oversamples the line, checks the start bit at mid-bit and samples every later bit at its centre. It flags parity, framing and overrun errors.

A two-entry transmit queue and a four-entry receive queue sit between the serial logic and the registers. Flow control works through a clear-to-send input that gates new characters and a request-to-send output that can drop when the receive queue fills. For testing, the line can be switched from normal operation to three other modes. Echo returns the received line to the transmit pin. Local loopback sends the transmitter into the receiver inside the block. Remote loopback returns the line but leaves the receiver idle. One interrupt output combines the status flags through a mask.

Top module: `uart_mm`

## Requirements
- R1: The oversampling tick fires once every DIV system clocks, where DIV is the 16-bit divisor (register 3 low byte, register 4 high byte, reset value 1; 0 acts as 1). One bit time is 16 ticks, so the start bit lasts 16·DIV clocks.
- R2: The frame on the line has the following parts, in order:
  - an idle level of 1;
  - one start bit of 0;
  - the data bits, least significant first, numbering ctrl[1:0]+5;
  - an optional parity bit;
  - the stop time, at level 1.
- R3: ctrl[3:2] selects parity: 1 means even, so the data ones plus the parity bit give an even count; 2 means odd; 0 and 3 mean no parity bit.
- R4: The stop time lasts 16+min(N,16) ticks, where N is register 2 bits [4:0]. When another character is waiting, the next start bit follows the stop time directly.
- R5: The transmit queue holds 2 characters and the receive queue holds 4, both in first-in first-out order. Writing register 0 pushes a character to transmit, and a write while the transmit queue is full is dropped. Reading register 0 pops the oldest received character.
- R6: The receiver accepts a start bit only if the line is still low at mid-bit, and it samples each later bit at its centre. A parity mismatch sets the sticky status[4], and the character is still stored.
- R7: A low level at the stop-bit sample sets the sticky status[5].
- R8: A character that completes while the receive queue is full is discarded and sets the sticky status[6].
- R9: When ctrl[6] is 1 and cts_n is high, no new character starts, while a character already being sent runs to its end. status[7] reads as the inverse of cts_n.
- R10: rts_n is low, except that it goes high while ctrl[7] is 1 and the receive queue is full.
- R11: ctrl[5:4] selects the line mode:
  - 0, normal;
  - 1, echo: txd follows rxd two clocks later and the receiver still takes in characters;
  - 2, local loopback: the transmitter feeds the receiver, txd is held at 1 and rxd is ignored;
  - 3, remote loopback: txd follows rxd and the receiver sees an idle line.
- R12: Register 6 reads as status, with these bits:
  - [0] receive data present;
  - [1] receive queue full;
  - [2] transmit queue has space;
  - [3] transmitter fully empty;
  - [6:4] the error flags.

  Writing 1 to any of status bits 6:4 clears that flag. irq is the OR of status[6:0] ANDed with the mask in register 5 bits [6:0].
- R13: After reset:
  - ctrl, stop and mask are 0;
  - the divisor is 1;
  - txd is 1;
  - irq is 0;
  - status reads {~cts_n, 7'b0001100}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 3 | Register select |
| wr | input | 1 | Write strobe, one cycle per access |
| rd | input | 1 | Read strobe; pops the receive queue at address 0 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Masked interrupt request |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Request to send, active low |

## Verification
The assertions assume that rxd and cts_n change only between clock edges and that a divisor write does not land in the middle of a frame. The bench drives these inputs on falling edges and changes the divisor only when the transmitter is idle. It builds every received frame at exactly 16·DIV clocks per bit. The only exception is a deliberately shortened low stop bit, which is held long enough to be sampled but not long enough to look like a new start bit.

// File: rtl/uart_mm_pkg.sv
// Shared types and constants for the multimode serial port.
// Assumes an 8-bit register interface and a 16-bit divisor.
package uart_mm_pkg;
    localparam int OSR   = 16;
    localparam int DIV_W = 16;

    localparam logic [1:0] PAR_EVEN = 2'd1;
    localparam logic [1:0] PAR_ODD  = 2'd2;

    localparam logic [2:0] A_DATA = 3'd0;
    localparam logic [2:0] A_CTRL = 3'd1;
    localparam logic [2:0] A_STOP = 3'd2;
    localparam logic [2:0] A_DIVL = 3'd3;
    localparam logic [2:0] A_DIVH = 3'd4;
    localparam logic [2:0] A_MASK = 3'd5;
    localparam logic [2:0] A_STAT = 3'd6;

    typedef enum logic [1:0] {MD_NORMAL, MD_ECHO, MD_LOCAL, MD_REMOTE} line_mode_e;

    typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} ser_state_e;

    typedef struct packed {
        logic       rts_auto;
        logic       cts_en;
        line_mode_e mode;
        logic [1:0] par;
        logic [1:0] len;
    } ctrl_t;
endpackage

// File: rtl/uart_mm_baud.sv
// Oversampling tick generator: one tick every div clocks (0 treated as 1).
// Assumes div is changed only while the line is quiet.
module uart_mm_baud #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] cnt;
    logic [W-1:0] lim;

    assign lim  = (div == '0) ? W'(1) : div;
    assign tick = (cnt >= lim - W'(1));

    // Count clocks between ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + W'(1);
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div > W'(1) && $stable(div)) |=> !tick); // R1
endmodule

// File: rtl/uart_mm_fifo.sv
// Small first-in first-out queue; a push when full and a pop when empty are dropped.
// Assumes DEPTH of at least 2.
module uart_mm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    // Storage array write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH)); // R5
endmodule

// File: rtl/uart_mm_tx.sv
// Transmit serializer: start, LSB-first data, optional parity, stop time in ticks.
// Assumes tick is one cycle wide; pops a new character only when avail and clear.
module uart_mm_tx
    import uart_mm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] len,
    input  logic [1:0] par,
    input  logic [5:0] stop_len,
    input  logic       avail,
    input  logic       clear,
    input  logic [7:0] din,
    output logic       pop,
    output logic       line,
    output logic       busy
);
    ser_state_e st;
    logic [5:0] cnt;
    logic [7:0] sh;
    logic [2:0] bidx;
    logic       pbit;
    logic [2:0] last_idx;
    logic [7:0] dmask;
    logic       bit_end, stop_end, has_par;

    assign last_idx = {1'b0, len} + 3'd4;
    assign dmask    = 8'hFF >> (2'd3 - len);
    assign bit_end  = (cnt == 6'd15);
    assign stop_end = (cnt == stop_len - 6'd1);
    assign has_par  = (par == PAR_EVEN) || (par == PAR_ODD);
    assign pop      = tick && avail && clear && (st == ST_IDLE || (st == ST_STOP && stop_end));
    assign busy     = (st != ST_IDLE);

    // Frame sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            sh   <= '0;
            bidx <= '0;
            pbit <= 1'b0;
        end else if (pop) begin
            st   <= ST_START;
            cnt  <= '0;
            sh   <= din;
            bidx <= '0;
            pbit <= ^(din & dmask) ^ (par == PAR_ODD);
        end else if (tick) begin
            case (st)
                ST_START: if (bit_end) begin st <= ST_DATA; cnt <= '0; end
                          else cnt <= cnt + 6'd1;
                ST_DATA:  if (bit_end) begin
                              cnt <= '0;
                              sh  <= sh >> 1;
                              if (bidx == last_idx) st <= has_par ? ST_PAR : ST_STOP;
                              else bidx <= bidx + 3'd1;
                          end else cnt <= cnt + 6'd1;
                ST_PAR:   if (bit_end) begin st <= ST_STOP; cnt <= '0; end
                          else cnt <= cnt + 6'd1;
                ST_STOP:  if (stop_end) st <= ST_IDLE;
                          else cnt <= cnt + 6'd1;
                default:  ;
            endcase
        end
    end

    // Line level per state.
    always_comb begin
        case (st)
            ST_START: line = 1'b0;
            ST_DATA:  line = sh[0];
            ST_PAR:   line = pbit;
            default:  line = 1'b1;
        endcase
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !clear) |=> (st == ST_IDLE)); // R9
endmodule

// File: rtl/uart_mm_rx.sv
// Receive deserializer on the 16x tick: mid-bit start check, centre sampling.
// Assumes rx_in is already synchronized to clk.
module uart_mm_rx
    import uart_mm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_in,
    input  logic [1:0] len,
    input  logic [1:0] par,
    output logic       done,
    output logic [7:0] data,
    output logic       perr,
    output logic       ferr
);
    ser_state_e st;
    logic [3:0] cnt;
    logic [7:0] sh;
    logic [2:0] bidx;
    logic       pbad;
    logic [2:0] last_idx;
    logic       has_par, exp_par;

    assign last_idx = {1'b0, len} + 3'd4;
    assign has_par  = (par == PAR_EVEN) || (par == PAR_ODD);
    assign exp_par  = ^sh ^ (par == PAR_ODD);

    // Frame sampler and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; cnt <= '0; sh <= '0; bidx <= '0; pbad <= 1'b0;
            done <= 1'b0; data <= '0; perr <= 1'b0; ferr <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (st)
                    ST_IDLE:  if (!rx_in) begin st <= ST_START; cnt <= '0; end
                    ST_START: if (cnt == 4'd7) begin
                                  cnt <= '0; bidx <= '0; sh <= '0; pbad <= 1'b0;
                                  st  <= rx_in ? ST_IDLE : ST_DATA;
                              end else cnt <= cnt + 4'd1;
                    ST_DATA:  if (cnt == 4'd15) begin
                                  cnt <= '0;
                                  sh[bidx] <= rx_in;
                                  if (bidx == last_idx) st <= has_par ? ST_PAR : ST_STOP;
                                  else bidx <= bidx + 3'd1;
                              end else cnt <= cnt + 4'd1;
                    ST_PAR:   if (cnt == 4'd15) begin
                                  cnt <= '0; pbad <= (rx_in != exp_par); st <= ST_STOP;
                              end else cnt <= cnt + 4'd1;
                    ST_STOP:  if (cnt == 4'd15) begin
                                  done <= 1'b1; data <= sh; perr <= pbad; ferr <= !rx_in;
                                  st <= ST_IDLE; cnt <= '0;
                              end else cnt <= cnt + 4'd1;
                    default:  st <= ST_IDLE;
                endcase
            end
        end
    end

    AST_RX_IDLE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && rx_in) |=> (st == ST_IDLE)); // R6
endmodule

// File: rtl/uart_mm.sv
// Multimode serial port top: register file, queues, line-mode routing, flags, irq.
// Assumes single-cycle wr/rd strobes and a register map fixed by uart_mm_pkg.
module uart_mm
    import uart_mm_pkg::*;
#(
    parameter int RX_DEPTH = 4,
    parameter int TX_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] addr,
    input  logic       wr,
    input  logic       rd,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq,
    input  logic       rxd,
    output logic       txd,
    input  logic       cts_n,
    output logic       rts_n
);
    ctrl_t            ctrl;
    logic [4:0]       stop_n;
    logic [DIV_W-1:0] div;
    logic [6:0]       mask;
    logic             perr_f, ferr_f, ovr_f;
    logic             rs1, rs2;
    logic             tick, tx_line, tx_busy, tx_pop, rx_in;
    logic [7:0]       tx_head, rx_head, rx_data;
    logic             tx_empty, tx_full, rx_empty, rx_full;
    logic             rx_done, rx_perr, rx_ferr;
    logic [5:0]       stop_len;
    logic [7:0]       status;
    logic             clr_wr;

    assign stop_len = 6'd16 + ((stop_n > 5'd16) ? 6'd16 : {1'b0, stop_n});
    assign clr_wr   = wr && (addr == A_STAT);
    assign status   = {~cts_n, ovr_f, ferr_f, perr_f, tx_empty && !tx_busy, !tx_full, rx_full, !rx_empty};
    assign irq      = |(status[6:0] & mask);
    assign rts_n    = ctrl.rts_auto && rx_full;

    // Two-flop synchronizer for the receive pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin rs1 <= 1'b1; rs2 <= 1'b1; end
        else        begin rs1 <= rxd;  rs2 <= rs1;  end
    end

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0; stop_n <= '0; div <= DIV_W'(1); mask <= '0;
        end else if (wr) begin
            case (addr)
                A_CTRL:  ctrl       <= ctrl_t'(wdata);
                A_STOP:  stop_n     <= wdata[4:0];
                A_DIVL:  div[7:0]   <= wdata;
                A_DIVH:  div[15:8]  <= wdata;
                A_MASK:  mask       <= wdata[6:0];
                default: ;
            endcase
        end
    end

    // Sticky error flags: set by the receiver, cleared by writing ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perr_f <= 1'b0; ferr_f <= 1'b0; ovr_f <= 1'b0;
        end else begin
            perr_f <= (perr_f && !(clr_wr && wdata[4])) || (rx_done && rx_perr);
            ferr_f <= (ferr_f && !(clr_wr && wdata[5])) || (rx_done && rx_ferr);
            ovr_f  <= (ovr_f  && !(clr_wr && wdata[6])) || (rx_done && rx_full);
        end
    end

    // Line routing per test mode.
    always_comb begin
        case (ctrl.mode)
            MD_ECHO:   begin txd = rs2;     rx_in = rs2;     end
            MD_LOCAL:  begin txd = 1'b1;    rx_in = tx_line; end
            MD_REMOTE: begin txd = rs2;     rx_in = 1'b1;    end
            default:   begin txd = tx_line; rx_in = rs2;     end
        endcase
    end

    // Register read multiplexer.
    always_comb begin
        case (addr)
            A_DATA:  rdata = rx_head;
            A_CTRL:  rdata = ctrl;
            A_STOP:  rdata = {3'b0, stop_n};
            A_DIVL:  rdata = div[7:0];
            A_DIVH:  rdata = div[15:8];
            A_MASK:  rdata = {1'b0, mask};
            A_STAT:  rdata = status;
            default: rdata = '0;
        endcase
    end

    uart_mm_baud #(.W(DIV_W)) u_baud (.clk(clk), .rst_n(rst_n), .div(div), .tick(tick));

    uart_mm_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(wr && addr == A_DATA), .din(wdata),
        .pop(tx_pop), .dout(tx_head), .empty(tx_empty), .full(tx_full));

    uart_mm_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_done), .din(rx_data),
        .pop(rd && addr == A_DATA), .dout(rx_head), .empty(rx_empty), .full(rx_full));

    uart_mm_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .len(ctrl.len), .par(ctrl.par),
        .stop_len(stop_len), .avail(!tx_empty), .clear(!ctrl.cts_en || !cts_n),
        .din(tx_head), .pop(tx_pop), .line(tx_line), .busy(tx_busy));

    uart_mm_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_in(rx_in), .len(ctrl.len),
        .par(ctrl.par), .done(rx_done), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr));

    AST_OVR_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_f) |-> $past(rx_full)); // R8
    AST_RX_AVAIL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(rx_done)); // R5
    AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status[6:0] != 7'd0)); // R12
endmodule

// File: tb/sim_uart_mm.sv
`timescale 1ns/1ps
module sim_uart_mm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq, txd, rts_n;
    logic       rxd = 1'b1, cts_n = 1'b0;
    int         errors = 0, checks = 0, divv = 1;
    bit         finished = 1'b0;

    uart_mm u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd), .wdata(wdata),
                .rdata(rdata), .irq(irq), .rxd(rxd), .txd(txd), .cts_n(cts_n), .rts_n(rts_n));

    always #2 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic wait_tx_idle();
        logic [7:0] s;
        for (int i = 0; i < 400; i++) begin
            rreg(3'd6, s);
            if (s[3]) break;
        end
    endtask

    task automatic drive_bit(input logic b, input int n);
        rxd = b;
        repeat (n) @(negedge clk);
    endtask

    task automatic rx_frame(input logic [7:0] d, input int nb, input int pm, input bit badp, input bit badstop);
        logic [7:0] m;
        m = 8'((1 << nb) - 1);
        @(negedge clk);
        drive_bit(1'b0, 16 * divv);
        for (int i = 0; i < nb; i++) drive_bit(d[i], 16 * divv);
        if (pm != 0) drive_bit(^(d & m) ^ (pm == 2) ^ badp, 16 * divv);
        if (badstop) drive_bit(1'b0, 10);
        drive_bit(1'b1, 16 * divv + 6);
    endtask

    task automatic tx_capture(input int nb, input int pm, output logic [7:0] d, output logic p, output logic stp);
        int t = 0;
        @(negedge clk);
        while (txd !== 1'b0 && t < 5000) begin @(negedge clk); t++; end
        if (t >= 5000) chk("R2 start bit timeout", 0, 1);
        repeat (8 * divv) @(negedge clk);
        d = '0; p = 1'b0;
        for (int i = 0; i < nb; i++) begin repeat (16 * divv) @(negedge clk); d[i] = txd; end
        if (pm != 0) begin repeat (16 * divv) @(negedge clk); p = txd; end
        repeat (16 * divv) @(negedge clk); stp = txd;
    endtask

    task automatic run_len(input logic lvl, output int n);
        int t = 0;
        n = 0;
        while (txd !== lvl && t < 5000) begin @(negedge clk); t++; end
        while (txd === lvl && n < 5000) begin @(negedge clk); n++; end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rreg(3'd6, v); chk("R13 status after reset", v, 8'h8C);
        rreg(3'd1, v); chk("R13 ctrl after reset", v, 0);
        rreg(3'd3, v); chk("R13 divisor low after reset", v, 1);
        chk("R13 irq after reset", irq, 0);
        chk("R13 txd idle", txd, 1);
        chk("R10 rts_n low by default", rts_n, 0);
    endtask

    task automatic t_local();
        logic [7:0] v;
        int hi = 0;
        wreg(3'd1, 8'h23);
        wreg(3'd0, 8'hA5);
        rxd = 1'b0;
        for (int i = 0; i < 220; i++) begin @(negedge clk); if (txd) hi++; end
        rxd = 1'b1;
        chk("R11 local loopback holds txd high", hi, 220);
        repeat (20) @(negedge clk);
        rreg(3'd6, v); chk("R11 local loopback char received", v[0], 1);
        rreg(3'd0, v); chk("R2 local loopback data", v, 8'hA5);
    endtask

    task automatic t_tx_format();
        logic [7:0] d; logic p, s;
        wreg(3'd1, 8'h06);
        wreg(3'd0, 8'h13);
        tx_capture(7, 1, d, p, s);
        chk("R2 tx 7-bit data", d, 8'h13);
        chk("R3 tx even parity bit", p, 1);
        chk("R2 tx stop level", s, 1);
        wait_tx_idle();
        wreg(3'd1, 8'h0B);
        wreg(3'd0, 8'h0F);
        tx_capture(8, 2, d, p, s);
        chk("R2 tx 8-bit data", d, 8'h0F);
        chk("R3 tx odd parity bit", p, 1);
        wait_tx_idle();
    endtask

    task automatic stop_case(input logic [7:0] n, input int exp, input string tag);
        int r;
        wreg(3'd2, n);
        wreg(3'd0, 8'h00);
        wreg(3'd0, 8'h00);
        run_len(1'b0, r);
        run_len(1'b1, r);
        chk(tag, r, exp);
        wait_tx_idle();
    endtask

    task automatic t_stop();
        wreg(3'd1, 8'h03);
        stop_case(8'd8, 24, "R4 stop of 1.5 bits");
        stop_case(8'd0, 16, "R4 stop of 1 bit");
        stop_case(8'd31, 32, "R4 stop clamped at 2 bits");
        wreg(3'd2, 8'd0);
    endtask

    task automatic t_div();
        int r;
        wreg(3'd1, 8'h03);
        wreg(3'd3, 8'd3);
        wreg(3'd0, 8'hFF);
        run_len(1'b0, r);
        chk("R1 start bit at divisor 3", r, 48);
        wait_tx_idle();
        wreg(3'd3, 8'd1);
    endtask

    task automatic t_rx_parity();
        logic [7:0] v;
        wreg(3'd1, 8'h08);
        rx_frame(8'h15, 5, 2, 1'b0, 1'b0);
        rreg(3'd6, v); chk("R6 good parity no error", v[4], 0);
        chk("R6 good parity char present", v[0], 1);
        rreg(3'd0, v); chk("R6 rx 5-bit data", v, 8'h15);
        rx_frame(8'h0A, 5, 2, 1'b1, 1'b0);
        rreg(3'd6, v); chk("R6 parity error flagged", v[4], 1);
        rreg(3'd0, v); chk("R6 char kept on parity error", v, 8'h0A);
        wreg(3'd6, 8'h10);
        rreg(3'd6, v); chk("R12 parity flag cleared", v[4], 0);
    endtask

    task automatic t_frame_err();
        logic [7:0] v;
        wreg(3'd1, 8'h03);
        rx_frame(8'h5A, 8, 0, 1'b0, 1'b1);
        rreg(3'd6, v); chk("R7 framing error flagged", v[5], 1);
        rreg(3'd0, v); chk("R7 data with bad stop", v, 8'h5A);
        wreg(3'd6, 8'h20);
        rreg(3'd6, v); chk("R7 framing flag cleared", v[5], 0);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        wreg(3'd5, 8'h00);
        rx_frame(8'h77, 8, 0, 1'b0, 1'b0);
        chk("R12 irq masked off", irq, 0);
        wreg(3'd5, 8'h01);
        chk("R12 irq on data present", irq, 1);
        rreg(3'd0, v); chk("R12 irq test data", v, 8'h77);
        chk("R12 irq drops after read", irq, 0);
        wreg(3'd5, 8'h00);
    endtask

    task automatic t_overrun();
        logic [7:0] v;
        wreg(3'd1, 8'hA3);
        for (int k = 0; k < 5; k++) begin
            for (int i = 0; i < 400; i++) begin rreg(3'd6, v); if (v[2]) break; end
            wreg(3'd0, 8'h11 + 8'(k));
        end
        wait_tx_idle();
        repeat (40) @(negedge clk);
        rreg(3'd6, v);
        chk("R5 rx queue full after 4", v[1], 1);
        chk("R8 overrun flagged", v[6], 1);
        chk("R10 rts_n raised on full", rts_n, 1);
        for (int k = 0; k < 4; k++) begin
            rreg(3'd0, v); chk("R8 kept chars in order", v, 8'h11 + k);
        end
        chk("R10 rts_n low after drain", rts_n, 0);
        rreg(3'd6, v); chk("R8 fifth char discarded", v[0], 0);
        wreg(3'd6, 8'h40);
    endtask

    task automatic t_cts();
        logic [7:0] v, d; logic p, s;
        int hi = 0;
        wreg(3'd1, 8'h43);
        cts_n = 1'b1;
        rreg(3'd6, v); chk("R9 status cts bit", v[7], 0);
        wreg(3'd0, 8'h31); wreg(3'd0, 8'h32); wreg(3'd0, 8'h33);
        rreg(3'd6, v); chk("R5 tx queue full", v[2], 0);
        for (int i = 0; i < 200; i++) begin @(negedge clk); if (txd) hi++; end
        chk("R9 held off while cts_n high", hi, 200);
        cts_n = 1'b0;
        tx_capture(8, 0, d, p, s); chk("R9 first char after release", d, 8'h31);
        tx_capture(8, 0, d, p, s); chk("R5 second char in order", d, 8'h32);
        hi = 0;
        for (int i = 0; i < 300; i++) begin @(negedge clk); if (txd) hi++; end
        chk("R5 write to full queue dropped", hi, 300);
        rreg(3'd6, v); chk("R5 tx empty after two", v[3], 1);
    endtask

    task automatic t_modes();
        logic [7:0] v;
        wreg(3'd1, 8'h13);
        rxd = 1'b0; repeat (3) @(negedge clk);
        chk("R11 echo follows low", txd, 0);
        rxd = 1'b1; repeat (3) @(negedge clk);
        chk("R11 echo follows high", txd, 1);
        repeat (30) @(negedge clk);
        rx_frame(8'h3C, 8, 0, 1'b0, 1'b0);
        rreg(3'd6, v); chk("R11 echo receiver active", v[0], 1);
        rreg(3'd0, v); chk("R11 echo received data", v, 8'h3C);
        wreg(3'd1, 8'h33);
        rxd = 1'b0; repeat (3) @(negedge clk);
        chk("R11 remote follows low", txd, 0);
        rxd = 1'b1; repeat (30) @(negedge clk);
        rx_frame(8'h3C, 8, 0, 1'b0, 1'b0);
        rreg(3'd6, v); chk("R11 remote receiver idle", v[0], 0);
        wreg(3'd1, 8'h03);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_local();
        t_tx_format();
        t_stop();
        t_div();
        t_rx_parity();
        t_frame_err();
        t_irq();
        t_overrun();
        t_cts();
        t_modes();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog R1-chain run: actual=hung expected=completed");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule